// File: doc/BRIEF.md
# Paired Edge/Level Interrupt Controller

This block is a first-level interrupt controller that gathers sixteen request sources into a single request line toward the processor. Half of the sources are external pins, which are active low and may each be treated either as a level or as a falling-edge event. The other half are internal level requests from on-chip logic. The two kinds alternate in the source numbering: pin 0, internal 0, pin 1, internal 1, and so on up to internal 7.

Software sees three 32-bit registers through a plain read/write port: a pending view, an enable mask and an edge-select register. Register bits are numbered from the most significant end, so source k sits at bit 31-k and the low half of every register is unused. A falling edge on a pin in edge mode is held in a per-pin two-state latch (states EDGE_IDLE and EDGE_HELD). The transition EDGE_IDLE to EDGE_HELD happens on a detected falling edge. EDGE_HELD returns to EDGE_IDLE on a write of one to that pin's pending bit when no new edge arrives in the same cycle. Either state goes to EDGE_IDLE whenever the pin is in level mode. The processor request is raised whenever any enabled source is pending, together with the number of the highest-priority enabled source.

Top module: `pirq_ctrl`

## Requirements
- R1: Register select 0 is pending, 1 is mask, 2 is edge-select; select 3 reads zero. Source k (pin j is k=2j, internal level j is k=2j+1) maps to bit 31-k. Bits 15..0 of every register read zero and ignore writes.
- R2: A pin in level mode shows pending while it is low, starting from the second rising clock edge after it goes low. An internal level shows pending in the same cycle it is high.
- R3: The mask register is readable and writable on bits 31..16. A set mask bit enables its source, a clear bit disables it. irq_o is high exactly when some source is both pending and enabled; masking never hides the pending view.
- R4: The edge-select register has one bit per pin, at bit 31-2j. A 1 selects falling-edge mode and a 0 selects level mode. The positions of internal levels read zero and ignore writes.
- R5: In edge mode a falling edge sets the pin's pending bit on the third rising clock edge after the pin goes low. The bit stays set after the pin returns high. A rising edge never sets it.
- R6: Writing 1 to an edge-mode pin's pending bit clears it. If a new falling edge is detected in the same cycle, the bit stays set.
- R7: Writing 1 to the pending bit of a level-mode pin or of an internal level has no effect.
- R8: vec_o gives the lowest-numbered source that is both pending and enabled while irq_o is high. vec_o is 0 while irq_o is low.
- R9: After reset, mask and edge-select are zero, no edge is held and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n_i | input | 8 | External pin requests, active low, asynchronous |
| int_lvl_i | input | 8 | Internal level requests, active high, synchronous |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Combined request to the processor |
| vec_o | output | 5 | Number of the highest-priority active source |

## Verification
A held edge latch left in the wrong state shows up as a pending bit that survives a clear, or one that never appears. This is visible on reg_rdata_o and irq_o in the cycle after the clear, or three cycles after the pin falls. A broken bit mapping or mask register shows up at once in read-back, and also in the vector, which must name the lowest enabled pending source. The clear-versus-new-edge collision is driven in the exact cycle in which the edge is detected. The bench also checks that clears aimed at level sources leave the read-back unchanged.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int unsigned REG_W = 32;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_EDGE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        EDGE_IDLE = 1'b0,
        EDGE_HELD = 1'b1
    } edge_st_e;
endpackage

// File: rtl/pirq_sync.sv
// Two-flop synchronizer for active-low pins plus a falling-edge detector.
module pirq_sync #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_n_i,
    output logic [NUM_PINS-1:0] pin_act_o,
    output logic [NUM_PINS-1:0] fall_o
);
    logic [NUM_PINS-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= pin_n_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pin_act_o = ~sync_q;
    assign fall_o    = prev_q & ~sync_q;
endmodule

// File: rtl/pirq_pending.sv
// Per-source pending view; one two-state edge latch per pin.
module pirq_pending
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    localparam int unsigned NSRC = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic [NUM_PINS-1:0] pin_act_i,
    input  logic [NUM_PINS-1:0] int_lvl_i,
    input  logic [NUM_PINS-1:0] edge_en_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NSRC-1:0]     src_pend_o,
    output logic [NUM_PINS-1:0] held_o
);
    for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin
        edge_st_e st_q, st_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= EDGE_IDLE;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            if (!edge_en_i[j]) begin
                st_d = EDGE_IDLE;
            end else begin
                unique case (st_q)
                    EDGE_IDLE: if (fall_i[j]) st_d = EDGE_HELD;
                    EDGE_HELD: if (clr_i[j] && !fall_i[j]) st_d = EDGE_IDLE;
                endcase
            end
        end

        assign held_o[j]         = (st_q == EDGE_HELD);
        assign src_pend_o[2*j]   = edge_en_i[j] ? held_o[j] : pin_act_i[j];
        assign src_pend_o[2*j+1] = int_lvl_i[j];
    end
endmodule

// File: rtl/pirq_prio.sv
// Lowest-numbered active source wins.
module pirq_prio #(
    parameter int unsigned NSRC  = 16,
    parameter int unsigned VEC_W = 5
) (
    input  logic [NSRC-1:0]  act_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        vec_o = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (act_i[k]) vec_o = VEC_W'(k);
        end
    end

    assign any_o = |act_i;
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned VEC_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_n_i,
    input  logic [NUM_PINS-1:0] int_lvl_i,
    input  logic [1:0]          reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    output logic                irq_o,
    output logic [VEC_W-1:0]    vec_o
);
    localparam int unsigned NSRC = 2 * NUM_PINS;

    reg_sel_e            sel;
    logic [NSRC-1:0]     wr_src, src_pend, mask_q;
    logic [NUM_PINS-1:0] wr_edge, edge_q, pin_clr, pin_act, pin_fall, pin_held;
    logic                pend_wr;
    logic                unused_wlow;

    assign sel         = reg_sel_e'(reg_addr_i);
    assign pend_wr     = reg_wr_i && (sel == SEL_PEND);
    assign unused_wlow = ^reg_wdata_i[REG_W-NSRC-1:0];

    // Unpack MSB-first register bits into source order.
    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign wr_src[k] = reg_wdata_i[REG_W-1-k];
    end
    for (genvar j = 0; j < NUM_PINS; j++) begin : g_pinbit
        assign wr_edge[j] = wr_src[2*j];
        assign pin_clr[j] = pend_wr && wr_src[2*j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            edge_q <= '0;
        end else if (reg_wr_i) begin
            unique case (sel)
                SEL_MASK: mask_q <= wr_src;
                SEL_EDGE: edge_q <= wr_edge;
                SEL_PEND, SEL_NONE: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_PEND: for (int k = 0; k < NSRC; k++) reg_rdata_o[REG_W-1-k] = src_pend[k];
            SEL_MASK: for (int k = 0; k < NSRC; k++) reg_rdata_o[REG_W-1-k] = mask_q[k];
            SEL_EDGE: for (int j = 0; j < NUM_PINS; j++) reg_rdata_o[REG_W-1-2*j] = edge_q[j];
            SEL_NONE: reg_rdata_o = '0;
        endcase
    end

    pirq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n_i   (pin_n_i),
        .pin_act_o (pin_act),
        .fall_o    (pin_fall)
    );

    pirq_pending #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (pin_fall),
        .pin_act_i  (pin_act),
        .int_lvl_i  (int_lvl_i),
        .edge_en_i  (edge_q),
        .clr_i      (pin_clr),
        .src_pend_o (src_pend),
        .held_o     (pin_held)
    );

    pirq_prio #(.NSRC(NSRC), .VEC_W(VEC_W)) u_prio (
        .act_i (src_pend & mask_q),
        .any_o (irq_o),
        .vec_o (vec_o)
    );
endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned VEC_W    = 5,
    localparam int unsigned NSRC    = 2 * NUM_PINS,
    localparam int unsigned IDX_W   = $clog2(NSRC),
    localparam int unsigned REG_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          reg_addr_i,
    input logic                reg_wr_i,
    input logic [REG_W-1:0]    reg_wdata_i,
    input logic [REG_W-1:0]    reg_rdata_o,
    input logic                irq_o,
    input logic [VEC_W-1:0]    vec_o,
    input logic [NSRC-1:0]     src_pend,
    input logic [NSRC-1:0]     mask_q,
    input logic [NUM_PINS-1:0] edge_q,
    input logic [NUM_PINS-1:0] pin_fall,
    input logic [NUM_PINS-1:0] pin_held
);
    logic [IDX_W-1:0] idx;
    logic [NSRC-1:0]  below;
    logic             pend_wr;

    assign idx     = vec_o[IDX_W-1:0];
    assign below   = (NSRC'(1) << idx) - NSRC'(1);
    assign pend_wr = reg_wr_i && (reg_addr_i == 2'd0);

    a_r1_low_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[REG_W-NSRC-1:0] == '0);

    a_r8_vec_names_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (src_pend[idx] && mask_q[idx]));

    a_r8_no_lower_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((src_pend & mask_q & below) == '0));

    a_r8_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == '0));

    for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin
        a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_wr && reg_wdata_i[REG_W-1-2*j] && !pin_fall[j]) |=> !pin_held[j]);

        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_q[j] && pin_fall[j]) |=> pin_held[j]);

        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_held[j] && edge_q[j] && !(pend_wr && reg_wdata_i[REG_W-1-2*j])) |=> pin_held[j]);

        a_r4_level_mode_drops: assert property (@(posedge clk) disable iff (!rst_n)
            !edge_q[j] |=> !pin_held[j]);
    end
endmodule

bind pirq_ctrl pirq_ctrl_chk #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .src_pend    (src_pend),
    .mask_q      (mask_q),
    .edge_q      (edge_q),
    .pin_fall    (pin_fall),
    .pin_held    (pin_held)
);

// File: tb/sim_pirq_ctrl.sv
`timescale 1ns/100ps
module sim_pirq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_n = 8'hFF;
    logic [7:0]  int_lvl = 8'h00;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [4:0]  vec;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Scoreboard queues: kind 0 = read data, 1 = irq, 2 = vector.
    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    pirq_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .pin_n_i (pin_n), .int_lvl_i (int_lvl),
        .reg_addr_i (reg_addr), .reg_wr_i (reg_wr), .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata), .irq_o (irq), .vec_o (vec)
    );

    function automatic logic [31:0] bsrc(input int k);
        return 32'h8000_0000 >> k;
    endfunction

    // Monitor: compares pending expectations away from the active edge.
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            int          kd;
            logic [31:0] ex, got;
            string       tg;
            kd = q_kind.pop_front();
            ex = q_exp.pop_front();
            tg = q_tag.pop_front();
            got = (kd == 0) ? reg_rdata : (kd == 1) ? {31'b0, irq} : {27'b0, vec};
            compared++;
            if (got !== ex) begin
                mismatched++;
                $display("FAIL %s: got %h expected %h", tg, got, ex);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk(input int kind, input logic [1:0] a, input logic [31:0] ex, input string tag);
        if (kind == 0) reg_addr = a;
        q_kind.push_back(kind); q_exp.push_back(ex); q_tag.push_back(tag);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R9 reset state
        chk(0, 2'd0, 32'h0, "R9 pending");
        chk(0, 2'd1, 32'h0, "R9 mask");
        chk(0, 2'd2, 32'h0, "R9 edge");
        chk(1, 2'd0, 32'h0, "R9 irq");
        chk(2, 2'd0, 32'h0, "R9 vec");

        // R1 / R3 / R4 register layout
        wr(2'd1, 32'hFFFF_FFFF);
        chk(0, 2'd1, 32'hFFFF_0000, "R1 R3 mask readback");
        wr(2'd2, 32'hFFFF_FFFF);
        chk(0, 2'd2, 32'hAAAA_0000, "R4 edge bits only at pins");
        wr(2'd2, 32'h0);
        chk(0, 2'd2, 32'h0, "R4 edge cleared");
        wr(2'd3, 32'hFFFF_FFFF);
        chk(0, 2'd3, 32'h0, "R1 select 3 reads zero");

        // R2 level pin latency (pin 3 = source 6)
        pin_n[3] = 1'b0;
        chk(0, 2'd0, 32'h0, "R2 before first edge");
        chk(0, 2'd0, 32'h0, "R2 after first edge");
        chk(0, 2'd0, bsrc(6), "R2 after second edge");
        chk(1, 2'd0, 32'h1, "R3 irq from pin");
        chk(2, 2'd0, 32'd6, "R8 vec pin 3");

        // R7 clears aimed at level sources
        int_lvl[2] = 1'b1;
        wr(2'd0, 32'hFFFF_FFFF);
        chk(0, 2'd0, bsrc(6) | bsrc(5), "R7 clear ignored on levels");
        chk(2, 2'd0, 32'd5, "R8 internal level 2 outranks pin 3");

        // R3 masking
        wr(2'd1, 32'hFFFF_0000 & ~bsrc(5));
        chk(2, 2'd0, 32'd6, "R3 masked source skipped");
        wr(2'd1, 32'h0);
        chk(1, 2'd0, 32'h0, "R3 all masked irq low");
        chk(2, 2'd0, 32'h0, "R8 vec zero when idle");
        chk(0, 2'd0, bsrc(6) | bsrc(5), "R3 pending visible while masked");

        // R8 boundaries
        wr(2'd1, 32'hFFFF_FFFF);
        int_lvl = 8'h80;
        pin_n[3] = 1'b1;
        tick(3);
        chk(0, 2'd0, bsrc(15), "R2 only internal level 7");
        chk(2, 2'd0, 32'd15, "R8 vec 15");
        pin_n[0] = 1'b0;
        tick(2);
        chk(2, 2'd0, 32'd0, "R8 vec 0 with pin 0");
        chk(1, 2'd0, 32'h1, "R8 irq with pin 0");
        pin_n[0] = 1'b1;
        int_lvl = 8'h00;
        tick(3);
        chk(0, 2'd0, 32'h0, "R2 all released");

        // R5 edge mode on pin 1 (source 2)
        wr(2'd2, bsrc(2));
        pin_n[1] = 1'b0;
        chk(0, 2'd0, 32'h0, "R5 edge P0");
        chk(0, 2'd0, 32'h0, "R5 edge P1");
        chk(0, 2'd0, 32'h0, "R5 edge P2");
        chk(0, 2'd0, bsrc(2), "R5 edge latched P3");
        pin_n[1] = 1'b1;
        tick(4);
        chk(0, 2'd0, bsrc(2), "R5 sticky after release");
        wr(2'd0, bsrc(2));
        chk(0, 2'd0, 32'h0, "R6 write one clears");

        pin_n[1] = 1'b0;
        tick(4);
        wr(2'd0, bsrc(2));
        pin_n[1] = 1'b1;
        tick(4);
        chk(0, 2'd0, 32'h0, "R5 rising edge ignored");

        // R6 collision: clear in the cycle the new edge is detected
        pin_n[1] = 1'b0;
        tick(4);
        pin_n[1] = 1'b1;
        tick(4);
        pin_n[1] = 1'b0;
        tick(2);
        wr(2'd0, bsrc(2));
        chk(0, 2'd0, bsrc(2), "R6 new edge wins over clear");
        wr(2'd0, bsrc(2));
        chk(0, 2'd0, 32'h0, "R6 later clear works");
        chk(1, 2'd0, 32'h0, "R6 irq low after clear");

        tick(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule